// File: doc/BRIEF.md
# Relay Step Sequencer with Skip

This block steps a bank of relay-drive outputs one at a time at a slow, fixed pace. It is meant for an equipment logic card. A local sequence-reset input, active low, holds the block at its home position. Two permission inputs, both active low, must be held active before any step is taken. Once the reset is released and both permissions are active, a prescaler gives one step tick every `CLK_HZ/STEP_HZ` clock cycles, and each tick moves the sequence on by one drive. The default pace is five steps per second. A skip input makes the sequence start at the fifth drive instead of the first. After the last drive the block halts by itself and raises a completion flag.

The fifth drive sets a sticky hold flop. That flop keeps the fifth drive output asserted after the sequence has moved on and after it has halted. While the hold is set, an auxiliary enable input switches on a pair of auxiliary relay outputs. The card reset, skip and both permission inputs each pass through a two-flop synchronizer before the logic uses them. A low card reset clears every piece of state, including the hold flop and the completion flag.

Top module: `relay_step_seq`

## Requirements
- R1: Drives are numbered from 1, and drive k is bit k-1 of `drive_o`. While the block runs, the active step is shown by exactly one drive bit, and the steps go up from the start drive to drive `N_DRIVES` (default 9).
- R2: Once the sequence has started, consecutive changes of `drive_o` are exactly `CLK_HZ/STEP_HZ` clock cycles apart.
- R3: While the synchronized card reset is low, `drive_o` is zero, `done_o` is 0 and `home_o` is 1. `home_o` falls when the first step is taken.
- R4: If either permission input is high (inactive), the sequence does not advance. A release of the card reset under that condition leaves every drive at 0 and `home_o` at 1.
- R5: If the skip input is high when the first step is taken, the sequence starts at drive `SKIP_STEP` (default 5). Only drives 5 to 9 are then stepped.
- R6: On the tick that follows the last drive, the step drive drops and `done_o` rises. After that, no further step is taken until the next card reset.
- R7: Drive `HOLD_STEP` (default 5, bit 4) stays asserted from the moment it is stepped until the next card reset, including after the block is done.
- R8: Both bits of `aux_o` are 1 exactly while the drive-5 hold is set and `aux_en_i` is 1. They are 0 otherwise, and a card reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| card_rst_n_i | input | 1 | Sequence reset, active low, asynchronous to clk |
| skip_i | input | 1 | Start at the skip step when high |
| go_hold_n_i | input | 1 | First permission, active low |
| pwr_hold_n_i | input | 1 | Second permission, active low |
| aux_en_i | input | 1 | Enables the auxiliary outputs while the hold is set |
| drive_o | output | N_DRIVES | Relay-drive outputs, bit k-1 is drive k |
| home_o | output | 1 | Counter at home (reset state) |
| done_o | output | 1 | Sequence has halted at terminal count |
| aux_o | output | 2 | Auxiliary relay outputs |

## Verification
The sequence is run three ways. The first is a full run from drive 1, which checks the order, the pacing and the point at which the hold engages. The second is a skip run, which checks that the start step moves while the terminal behaviour stays the same. The third is a set of releases with one or both permissions inactive, which must produce no drive activity at all. The aux enable is toggled after the halt to show that the auxiliary pair depends on the enable and not only on the hold. A card reset after a completed run must clear the hold, the done flag and the auxiliary pair, which separates a sticky hold from a stuck one.

// File: rtl/relay_seq_pkg.sv
package relay_seq_pkg;

    localparam int STEP_W = 8;

    typedef enum logic [1:0] {
        PH_HOME = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [STEP_W-1:0]   idx;
    } seq_state_t;

    localparam seq_state_t SEQ_IDLE = '{phase: PH_HOME, idx: '0};

    typedef struct packed {
        logic card_rst_n;
        logic skip;
        logic go_n;
        logic pwr_n;
    } ctl_in_t;

    localparam ctl_in_t CTL_RST = '{card_rst_n: 1'b0, skip: 1'b0, go_n: 1'b1, pwr_n: 1'b1};

    function automatic seq_state_t seq_next(input seq_state_t cur, input logic skip,
                                            input int last, input int skip_step);
        seq_state_t nx;
        nx = cur;
        case (cur.phase)
            PH_HOME: begin
                nx.phase = PH_RUN;
                nx.idx   = skip ? STEP_W'(skip_step) : STEP_W'(1);
            end
            PH_RUN: begin
                if (cur.idx == STEP_W'(last)) begin
                    nx.phase = PH_DONE;
                    nx.idx   = '0;
                end else begin
                    nx.idx = cur.idx + 1'b1;
                end
            end
            default: nx = cur;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/ctl_sync2.sv
module ctl_sync2 #(
    parameter int               WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/step_prescaler.sv
module step_prescaler #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int STEP_HZ = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    output logic tick_o
);
    localparam int DIV   = (CLK_HZ / STEP_HZ) < 2 ? 2 : (CLK_HZ / STEP_HZ);
    localparam int CNT_W = $clog2(DIV);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == CNT_W'(DIV - 1)) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o) else $error("tick wider than one cycle"); // R2
endmodule

// File: rtl/step_counter.sv
module step_counter
    import relay_seq_pkg::*;
#(
    parameter int N_DRIVES  = 9,
    parameter int SKIP_STEP = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear_i,
    input  logic                tick_i,
    input  logic                permit_i,
    input  logic                skip_i,
    output logic [N_DRIVES-1:0] step_vec_o,
    output logic                home_o,
    output logic                done_o
);
    seq_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            st_q <= SEQ_IDLE;
        end else if (tick_i && permit_i) begin
            st_q <= seq_next(st_q, skip_i, N_DRIVES, SKIP_STEP);
        end
    end

    for (genvar g = 0; g < N_DRIVES; g++) begin : g_dec
        assign step_vec_o[g] = (st_q.phase == PH_RUN) && (st_q.idx == STEP_W'(g + 1));
    end

    assign home_o = (st_q.phase == PH_HOME);
    assign done_o = (st_q.phase == PH_DONE);

    AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_vec_o)) else $error("more than one step active"); // R1
    AST_ADV_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !clear_i) |=> $stable(st_q)) else $error("step moved without tick"); // R2
    AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (home_o && !permit_i) |=> home_o) else $error("start without permission"); // R4
    AST_SKIP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (home_o && tick_i && permit_i && skip_i && !clear_i) |=> step_vec_o[SKIP_STEP-1])
        else $error("skip entry wrong"); // R5
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done_o && !clear_i) |=> (done_o && step_vec_o == '0)) else $error("left done state"); // R6
endmodule

// File: rtl/relay_step_seq.sv
module relay_step_seq
    import relay_seq_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int STEP_HZ   = 5,
    parameter int N_DRIVES  = 9,
    parameter int SKIP_STEP = 5,
    parameter int HOLD_STEP = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                card_rst_n_i,
    input  logic                skip_i,
    input  logic                go_hold_n_i,
    input  logic                pwr_hold_n_i,
    input  logic                aux_en_i,
    output logic [N_DRIVES-1:0] drive_o,
    output logic                home_o,
    output logic                done_o,
    output logic [1:0]          aux_o
);
    localparam int HOLD_BIT = HOLD_STEP - 1;

    ctl_in_t ctl_raw, ctl_s;
    logic    clear, permit, tick, hold_q;
    logic [N_DRIVES-1:0] step_vec;

    assign ctl_raw = '{card_rst_n: card_rst_n_i, skip: skip_i,
                       go_n: go_hold_n_i, pwr_n: pwr_hold_n_i};

    ctl_sync2 #(.WIDTH($bits(ctl_in_t)), .RST_VAL(CTL_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ctl_raw),
        .q_o (ctl_s)
    );

    assign clear  = !ctl_s.card_rst_n;
    assign permit = !ctl_s.go_n && !ctl_s.pwr_n;

    step_prescaler #(.CLK_HZ(CLK_HZ), .STEP_HZ(STEP_HZ)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear),
        .tick_o  (tick)
    );

    step_counter #(.N_DRIVES(N_DRIVES), .SKIP_STEP(SKIP_STEP)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear),
        .tick_i     (tick),
        .permit_i   (permit),
        .skip_i     (ctl_s.skip),
        .step_vec_o (step_vec),
        .home_o     (home_o),
        .done_o     (done_o)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hold_q <= 1'b0;
        end else if (step_vec[HOLD_BIT]) begin
            hold_q <= 1'b1;
        end
    end

    always_comb begin
        drive_o           = step_vec;
        drive_o[HOLD_BIT] = step_vec[HOLD_BIT] | hold_q;
    end

    assign aux_o = {2{hold_q & aux_en_i}};

    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !clear) |=> drive_o[HOLD_BIT]) else $error("hold dropped"); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clear |=> (drive_o == '0 && !done_o && home_o && aux_o == 2'b00))
        else $error("card reset did not clear"); // R3
endmodule

// File: tb/relay_step_seq_tb.sv
`timescale 1ns/1ps
module relay_step_seq_tb;
    localparam int CLK_HZ  = 80;
    localparam int STEP_HZ = 10;
    localparam int DIV     = CLK_HZ / STEP_HZ;
    localparam int ND      = 9;

    logic clk = 1'b0;
    logic rst, card_rst_n, skip, go_n, pwr_n, aux_en;
    logic [ND-1:0] drive_o;
    logic home_o, done_o;
    logic [1:0] aux_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [ND-1:0] exp_q[$];
    logic [ND-1:0] prev_drv = '0;
    int gap = 0;

    always #5 clk = ~clk;

    relay_step_seq #(.CLK_HZ(CLK_HZ), .STEP_HZ(STEP_HZ)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .card_rst_n_i (card_rst_n),
        .skip_i       (skip),
        .go_hold_n_i  (go_n),
        .pwr_hold_n_i (pwr_n),
        .aux_en_i     (aux_en),
        .drive_o      (drive_o),
        .home_o       (home_o),
        .done_o       (done_o),
        .aux_o        (aux_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // expected pattern after each step change (R1, R7), then the done pattern (R6)
    task automatic push_run(input logic do_skip);
        logic [ND-1:0] p;
        for (int k = (do_skip ? 5 : 1); k <= ND; k++) begin
            p = '0;
            p[k-1] = 1'b1;
            if (k > 5) p[4] = 1'b1;
            exp_q.push_back(p);
        end
        p = '0;
        p[4] = 1'b1;
        exp_q.push_back(p);
    endtask

    task automatic wait_drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 40 * DIV) begin
            @(negedge clk);
            t++;
        end
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // monitor: pops expected drive patterns as they appear
    always @(negedge clk) begin
        if (!rst) begin
            gap++;
            if (drive_o !== prev_drv) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected drive change", int'(drive_o), int'(prev_drv));
                end else begin
                    logic [ND-1:0] e;
                    e = exp_q.pop_front();
                    check(drive_o === e, "R1 step order", int'(drive_o), int'(e));
                end
                if (prev_drv != '0 && drive_o != '0)
                    check(gap == DIV, "R2 step interval", gap, DIV);
                gap = 0;
                prev_drv = drive_o;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        rst = 1'b1; card_rst_n = 1'b0; skip = 1'b0;
        go_n = 1'b1; pwr_n = 1'b1; aux_en = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(drive_o == '0, "R3 reset drives", int'(drive_o), 0);
        check(home_o == 1'b1, "R3 home in reset", int'(home_o), 1);
        check(done_o == 1'b0, "R3 done in reset", int'(done_o), 0);
        check(aux_o == 2'b00, "R8 aux in reset", int'(aux_o), 0);

        // R4: release with no permission, then with only one
        card_rst_n = 1'b1;
        repeat (12 * DIV) @(negedge clk);
        check(drive_o == '0 && home_o, "R4 no permits", int'(drive_o), 0);
        go_n = 1'b0;
        repeat (12 * DIV) @(negedge clk);
        check(drive_o == '0 && home_o, "R4 one permit", int'(drive_o), 0);
        go_n = 1'b1; pwr_n = 1'b0;
        repeat (12 * DIV) @(negedge clk);
        check(drive_o == '0 && home_o, "R4 other permit", int'(drive_o), 0);

        // full run from drive 1
        card_rst_n = 1'b0;
        repeat (6) @(negedge clk);
        go_n = 1'b0; pwr_n = 1'b0; aux_en = 1'b1;
        push_run(1'b0);
        card_rst_n = 1'b1;
        wait_drain("R1 full run complete");
        repeat (2) @(negedge clk);
        check(done_o == 1'b1, "R6 done raised", int'(done_o), 1);
        check(home_o == 1'b0, "R3 home after start", int'(home_o), 0);
        check(drive_o == 9'h010, "R7 hold after done", int'(drive_o), 'h10);
        check(aux_o == 2'b11, "R8 aux with hold", int'(aux_o), 3);
        repeat (4 * DIV) @(negedge clk);
        check(done_o == 1'b1 && drive_o == 9'h010, "R6 halted", int'(drive_o), 'h10);
        aux_en = 1'b0;
        @(negedge clk);
        check(aux_o == 2'b00, "R8 aux disabled", int'(aux_o), 0);
        aux_en = 1'b1;
        @(negedge clk);
        check(aux_o == 2'b11, "R8 aux re-enabled", int'(aux_o), 3);

        // card reset clears hold, done, aux
        exp_q.push_back('0);
        card_rst_n = 1'b0;
        repeat (6) @(negedge clk);
        check(drive_o == '0, "R7 hold cleared", int'(drive_o), 0);
        check(done_o == 1'b0 && home_o == 1'b1, "R3 cleared state", int'(done_o), 0);
        check(aux_o == 2'b00, "R8 aux cleared", int'(aux_o), 0);
        check(exp_q.size() == 0, "R3 reset change seen", exp_q.size(), 0);

        // skip run
        skip = 1'b1;
        push_run(1'b1);
        card_rst_n = 1'b1;
        wait_drain("R5 skip run complete");
        repeat (2) @(negedge clk);
        check(done_o == 1'b1 && drive_o == 9'h010, "R5 skip end state", int'(drive_o), 'h10);
        finish_run();
    end
endmodule